// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a programmable sum-of-products device. A wide AND array outside the block forms product terms; this cell receives twelve of them as plain input bits, in three groups of four. Each group is ORed into a sum term. A mode field decides how the three sum terms are split between the output path and two independent flip-flops, so one cell can drive a registered or combinational output and still keep both registers busy as buried state.

Every register has its own reset term and its own clock term, and a preset line shared by a bank of cells can set it. Clock terms act as clock enables on one system clock. The output has its own enable term, and a polarity bit sets whether the pin is active high or active low. The cell returns six feedback signals to the array: the true and complement of the pin and of each register.

Top module: `plmc_cell`

## Requirements
- R1: Each sum term is the OR of its own four product terms. The top group is `pt_in[3:0]`, the middle group is `pt_in[7:4]` and the bottom group is `pt_in[11:8]`. Any single asserted term in a group asserts that group's sum.
- R2: When `mode_sel` = 3'b000 (registered, eight terms), register A loads top OR middle, and the pin carries register A through the polarity stage.
- R3: When `mode_sel` = 3'b001 (registered, twelve terms), register A loads top OR middle OR bottom, and the pin carries register A.
- R4: When `mode_sel` is 3'b010, 3'b011 or 3'b100, the pin is combinational: top only, top OR middle, or all three sums. In these modes register A loads the middle sum only.
- R5: Register B loads the bottom sum in every mode.
- R6: The codes 3'b101, 3'b110 and 3'b111 behave exactly like 3'b000.
- R7: When `pol_high` = 1 the pin equals the selected value. When `pol_high` = 0 the pin is its inverse.
- R8: A register takes a new value on a rising clock edge only while its clock term is high. Otherwise it holds its value.
- R9: A register's reset term forces that register's output low at once. The register is then cleared at the next edge, with priority over preset and clock, and the other register is not affected.
- R10: When `bank_preset` is high, a register whose clock term is high is set to 1 at the edge, whatever its D input. When the clock term is low, the preset has no effect.
- R11: `pin_oe` follows the enable term. While it is low, the pin feedback follows `pin_in` and not the internal value.
- R12: `fb_out` is ordered {B, ~B, A, ~A, pin, ~pin} from bit 5 down to bit 0.
- R13: After reset both registers are low. A registered-mode pin then reads 1 with `pol_high` = 0 and 0 with `pol_high` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| pt_in | input | 12 | Product terms: top [3:0], middle [7:4], bottom [11:8] |
| ta_rst | input | 1 | Reset term, register A |
| ta_clk | input | 1 | Clock-enable term, register A |
| tb_rst | input | 1 | Reset term, register B |
| tb_clk | input | 1 | Clock-enable term, register B |
| t_oe | input | 1 | Output-enable term |
| bank_preset | input | 1 | Synchronous preset shared by a bank |
| mode_sel | input | 3 | Sum-term steering mode |
| pol_high | input | 1 | 1 = active-high pin, 0 = active-low pin |
| pin_in | input | 1 | Level seen on the external pin |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 6 | Feedback to the array |

## Verification
The hardest state to reach from the ports is a reset term that is high in the same cycle as the preset and the clock term, while the other register holds a 1 that must survive. Seeing this needs a sample before the edge, to show the output is masked at once, and another after the edge, to show the register really cleared. The bench first loads register B through the bottom group, then puts register A's reset together with preset and clock at a falling edge. It checks the feedback in the middle of that cycle, then releases everything and looks again.

// File: rtl/plmc_pkg.sv
package plmc_pkg;

   typedef enum logic [2:0] {
      MODE_REG8   = 3'd0,
      MODE_REG12  = 3'd1,
      MODE_COMB4  = 3'd2,
      MODE_COMB8  = 3'd3,
      MODE_COMB12 = 3'd4
   } cell_mode_e;

   typedef struct packed {
      logic d_a;
      logic d_b;
      logic comb_raw;
      logic is_comb;
   } route_t;

   localparam int NUM_SUMS = 3;
   localparam int FB_W     = 6;

   function automatic cell_mode_e norm_mode(input logic [2:0] code);
      case (code)
         3'd1:    return MODE_REG12;
         3'd2:    return MODE_COMB4;
         3'd3:    return MODE_COMB8;
         3'd4:    return MODE_COMB12;
         default: return MODE_REG8;
      endcase
   endfunction

endpackage

// File: rtl/plmc_sum_group.sv
module plmc_sum_group #(
   parameter int N_TERMS = 4,
   parameter bit CHAINED = 1'b0
) (
   input  logic [N_TERMS-1:0] terms,
   output logic               sum
);
   generate
      if (N_TERMS < 1) begin : g_bad
         $error("plmc_sum_group: N_TERMS must be at least 1");
      end
      if (CHAINED) begin : g_chain
         logic [N_TERMS-1:0] part;
         assign part[0] = terms[0];
         for (genvar i = 1; i < N_TERMS; i++) begin : g_link
            assign part[i] = part[i-1] | terms[i];
         end
         assign sum = part[N_TERMS-1];
      end else begin : g_reduce
         assign sum = |terms;
      end
   endgenerate
endmodule

// File: rtl/plmc_route.sv
module plmc_route
   import plmc_pkg::*;
(
   input  logic       s_top,
   input  logic       s_mid,
   input  logic       s_bot,
   input  logic [2:0] mode_code,
   output route_t     route
);
   cell_mode_e mode;

   always_comb begin
      mode           = norm_mode(mode_code);
      route.d_b      = s_bot;
      route.d_a      = s_mid;
      route.comb_raw = 1'b0;
      route.is_comb  = 1'b0;
      case (mode)
         MODE_REG12: route.d_a = s_top | s_mid | s_bot;
         MODE_COMB4: begin
            route.is_comb  = 1'b1;
            route.comb_raw = s_top;
         end
         MODE_COMB8: begin
            route.is_comb  = 1'b1;
            route.comb_raw = s_top | s_mid;
         end
         MODE_COMB12: begin
            route.is_comb  = 1'b1;
            route.comb_raw = s_top | s_mid | s_bot;
         end
         default: route.d_a = s_top | s_mid;
      endcase
   end
endmodule

// File: rtl/plmc_reg.sv
module plmc_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic ck,
   input  logic ar,
   input  logic preset,
   output logic q
);
   logic q_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_reg <= 1'b0;
      else if (ar)      q_reg <= 1'b0;
      else if (ck)      q_reg <= preset ? 1'b1 : d;
   end

   assign q = q_reg & ~ar;

   assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ar |=> (q_reg == 1'b0));
   assert_hold_without_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ar && !ck) |=> $stable(q_reg));
   assert_load_on_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ar && ck && !preset) |=> (q_reg == $past(d)));
   assert_preset_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ar && ck && preset) |=> q_reg);
endmodule

// File: rtl/plmc_outbuf.sv
module plmc_outbuf (
   input  logic reg_a,
   input  logic comb_raw,
   input  logic is_comb,
   input  logic pol_high,
   input  logic oe,
   input  logic pin_in,
   output logic pin_out,
   output logic pin_oe,
   output logic pin_fb
);
   logic raw;

   always_comb begin
      raw     = is_comb ? comb_raw : reg_a;
      pin_out = pol_high ? raw : ~raw;
      pin_oe  = oe;
      pin_fb  = oe ? pin_out : pin_in;
   end
endmodule

// File: rtl/plmc_cell.sv
module plmc_cell
   import plmc_pkg::*;
#(
   parameter int PT_PER_SUM = 4,
   parameter bit CHAINED_OR = 1'b0,
   localparam int PT_W = NUM_SUMS * PT_PER_SUM
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PT_W-1:0] pt_in,
   input  logic            ta_rst,
   input  logic            ta_clk,
   input  logic            tb_rst,
   input  logic            tb_clk,
   input  logic            t_oe,
   input  logic            bank_preset,
   input  logic [2:0]      mode_sel,
   input  logic            pol_high,
   input  logic            pin_in,
   output logic            pin_out,
   output logic            pin_oe,
   output logic [FB_W-1:0] fb_out
);
   generate
      if (PT_PER_SUM < 1 || PT_PER_SUM > 64) begin : g_bad_width
         $error("plmc_cell: PT_PER_SUM out of range");
      end
   endgenerate

   logic [NUM_SUMS-1:0] sums;
   route_t              route;
   logic [1:0]          q_vis;
   logic [1:0]          d_vec, ck_vec, ar_vec;
   logic                pin_fb;

   for (genvar g = 0; g < NUM_SUMS; g++) begin : g_sum
      plmc_sum_group #(.N_TERMS(PT_PER_SUM), .CHAINED(CHAINED_OR)) u_sum (
         .terms (pt_in[g*PT_PER_SUM +: PT_PER_SUM]),
         .sum   (sums[g])
      );
   end

   plmc_route u_route (
      .s_top     (sums[0]),
      .s_mid     (sums[1]),
      .s_bot     (sums[2]),
      .mode_code (mode_sel),
      .route     (route)
   );

   assign d_vec  = {route.d_b, route.d_a};
   assign ck_vec = {tb_clk, ta_clk};
   assign ar_vec = {tb_rst, ta_rst};

   for (genvar r = 0; r < 2; r++) begin : g_reg
      plmc_reg u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .d      (d_vec[r]),
         .ck     (ck_vec[r]),
         .ar     (ar_vec[r]),
         .preset (bank_preset),
         .q      (q_vis[r])
      );
   end

   plmc_outbuf u_out (
      .reg_a    (q_vis[0]),
      .comb_raw (route.comb_raw),
      .is_comb  (route.is_comb),
      .pol_high (pol_high),
      .oe       (t_oe),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .pin_fb   (pin_fb)
   );

   assign fb_out = {q_vis[1], ~q_vis[1], q_vis[0], ~q_vis[0], pin_fb, ~pin_fb};

   assert_pin_feedback_external_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> (fb_out[1] == pin_in));
   assert_reg_pin_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 3'd0 && pin_oe) |-> (pin_out == (pol_high ? fb_out[3] : fb_out[2])));
   assert_reg_b_mode_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tb_rst && tb_clk && !bank_preset) |=> (fb_out[5] == $past(|pt_in[2*PT_PER_SUM +: PT_PER_SUM])));
endmodule

// File: tb/plmc_cell_tb.sv
module plmc_cell_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] pt_in = '0;
   logic        ta_rst = 0, ta_clk = 0, tb_rst = 0, tb_clk = 0, t_oe = 1;
   logic        bank_preset = 0, pol_high = 0, pin_in = 0;
   logic [2:0]  mode_sel = 3'd0;
   logic        pin_out, pin_oe;
   logic [5:0]  fb_out;
   int          n_checks = 0, n_fail = 0;

   always #4 clk = ~clk;

   plmc_cell u_dut (
      .clk(clk), .rst_n(rst_n), .pt_in(pt_in), .ta_rst(ta_rst), .ta_clk(ta_clk),
      .tb_rst(tb_rst), .tb_clk(tb_clk), .t_oe(t_oe), .bank_preset(bank_preset),
      .mode_sel(mode_sel), .pol_high(pol_high), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
   );

   // {mode, pol, pt (bottom,middle,top nibbles), expected {pin, regA, regB}}
   localparam int NVEC = 15;
   localparam logic [18:0] VECS [0:NVEC-1] = '{
      {3'd0, 1'b1, 12'h001, 3'b110},
      {3'd0, 1'b1, 12'h100, 3'b001},
      {3'd0, 1'b0, 12'h020, 3'b010},
      {3'd1, 1'b1, 12'h800, 3'b111},
      {3'd1, 1'b1, 12'h000, 3'b000},
      {3'd2, 1'b1, 12'h004, 3'b100},
      {3'd2, 1'b1, 12'h040, 3'b010},
      {3'd3, 1'b1, 12'h040, 3'b110},
      {3'd3, 1'b1, 12'h400, 3'b001},
      {3'd4, 1'b1, 12'h400, 3'b101},
      {3'd4, 1'b0, 12'h200, 3'b001},
      {3'd5, 1'b1, 12'h010, 3'b110},
      {3'd7, 1'b1, 12'h200, 3'b001},
      {3'd6, 1'b0, 12'h000, 3'b100},
      {3'd2, 1'b0, 12'h000, 3'b100}
   };

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string mode_req(input logic [2:0] m);
      case (m)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2, 3'd3, 3'd4: return "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired, run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R13: reset state, registered mode, active-low pin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13", "fb after reset", {2'b0, fb_out}, 8'b0001_0110);
      chk("R13", "pin low-active after reset", {7'b0, pin_out}, 8'd1);
      pol_high = 1'b1;
      #1;
      chk("R13", "pin high-active after reset", {7'b0, pin_out}, 8'd0);

      // Vector table: R2 R3 R4 R5 R6 R7 R12
      ta_clk = 1; tb_clk = 1; t_oe = 1;
      for (int i = 0; i < NVEC; i++) begin
         logic [2:0]  m;
         logic        p;
         logic [11:0] pt;
         logic [2:0]  e;
         {m, p, pt, e} = VECS[i];
         mode_sel = m; pol_high = p; pt_in = pt;
         step();
         chk(mode_req(m), "pin (R7 polarity)", {7'b0, pin_out}, {7'b0, e[2]});
         chk(mode_req(m), "register A", {7'b0, fb_out[3]}, {7'b0, e[1]});
         chk("R5", "register B", {7'b0, fb_out[5]}, {7'b0, e[0]});
         chk("R12", "feedback order", {2'b0, fb_out},
             {2'b0, e[0], ~e[0], e[1], ~e[1], e[2], ~e[2]});
      end

      // R8: clock term gates loading
      mode_sel = 3'd0; pol_high = 1; pt_in = 12'h000; ta_clk = 1; tb_clk = 1;
      step();
      pt_in = 12'h101; ta_clk = 0;
      step();
      chk("R8", "A holds with clock term low", {7'b0, fb_out[3]}, 8'd0);
      chk("R8", "B loads with clock term high", {7'b0, fb_out[5]}, 8'd1);
      ta_clk = 1;
      step();
      chk("R8", "A loads with clock term high", {7'b0, fb_out[3]}, 8'd1);

      // R9: reset term masks at once, clears at edge, beats preset and clock
      tb_clk = 0; pt_in = 12'h001;
      ta_rst = 1; ta_clk = 1; bank_preset = 1;
      #1;
      chk("R9", "A masked immediately", {7'b0, fb_out[3]}, 8'd0);
      chk("R9", "pin follows masked A", {7'b0, pin_out}, 8'd0);
      step();
      chk("R9", "A low under reset+preset+clock", {7'b0, fb_out[3]}, 8'd0);
      chk("R9", "B untouched by A reset", {7'b0, fb_out[5]}, 8'd1);
      ta_rst = 0; ta_clk = 0; bank_preset = 0;
      step();
      chk("R9", "A stays cleared after release", {7'b0, fb_out[3]}, 8'd0);

      // R10: preset needs the clock term
      pt_in = 12'h000; bank_preset = 1; ta_clk = 0;
      step();
      chk("R10", "preset ignored without clock term", {7'b0, fb_out[3]}, 8'd0);
      ta_clk = 1;
      step();
      chk("R10", "preset sets A despite D=0", {7'b0, fb_out[3]}, 8'd1);
      bank_preset = 0;
      step();
      chk("R10", "A reloads D after preset drops", {7'b0, fb_out[3]}, 8'd0);
      bank_preset = 1; tb_rst = 1; tb_clk = 1;
      step();
      chk("R9", "B reset beats preset", {7'b0, fb_out[5]}, 8'd0);
      chk("R10", "A preset alongside", {7'b0, fb_out[3]}, 8'd1);
      bank_preset = 0; tb_rst = 0; tb_clk = 0; ta_clk = 0;

      // R11: output enable and pin feedback
      t_oe = 0; pin_in = 1;
      #1;
      chk("R11", "pin_oe low", {7'b0, pin_oe}, 8'd0);
      chk("R11", "pin fb follows external 1", {6'b0, fb_out[1:0]}, 8'b10);
      pin_in = 0;
      #1;
      chk("R11", "pin fb follows external 0", {6'b0, fb_out[1:0]}, 8'b01);
      t_oe = 1;
      #1;
      chk("R11", "pin fb follows driven value", {6'b0, fb_out[1:0]}, 8'b10);

      // R1: each product term alone asserts the twelve-term output
      mode_sel = 3'd4; pol_high = 1;
      for (int b = 0; b < 12; b++) begin
         pt_in = 12'h001 << b;
         #1;
         chk("R1", $sformatf("term %0d alone", b), {7'b0, pin_out}, 8'd1);
      end
      pt_in = 12'h000;
      #1;
      chk("R1", "no terms", {7'b0, pin_out}, 8'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule